// File: doc/BRIEF.md
# Piecewise-Linear Neuron Activation Unit

This unit turns a neuron's weighted-sum value into its activation output. Each sample is a signed 16-bit fixed-point number with 12 fractional bits, so one unit is 4096. The curve is not looked up point by point. It is rebuilt from 21 stored breakpoints that are evenly spaced half a unit apart, from -5.0 to +5.0, with a straight line between each pair of neighbouring breakpoints.

A bank of parallel comparators finds the segment that holds the input and gives one segment index. That index reads two coefficient tables at the same time: one gives the slope of the segment and the other gives its intercept. A multiply-add stage then forms slope times input, shifted right by the 12 fractional bits, plus the intercept. A select bit that travels with each sample chooses the logistic (sigmoid) curve or the hyperbolic-tangent curve.

The unit is a four-stage pipeline: compare, coefficient read, multiply, add. A valid strobe moves through the pipeline alongside the data. The unit accepts a new sample on every cycle.

Top module: `pwl_act`

## Requirements
- R1: A sample taken with `in_valid` high at a rising edge gives `out_valid` high, with its result on `out_y`, exactly four rising edges later. Results leave in the order the samples arrived, and `out_valid` is never high for any other reason.
- R2: Breakpoint k (k = 0..20) sits at input code -20480 + 2048·k. With `in_sel` = 0 the node values are the logistic curve in 4.12 format. For k = 10..20 these are 2048, 2550, 2994, 3349, 3608, 3785, 3902, 3976, 4022, 4051, 4069. For k < 10 the value is 4096 minus the value at 20 − k.
- R3: With `in_sel` = 1 the node values are the hyperbolic tangent in 4.12 format. For k = 10..20 these are 0, 1893, 3119, 3707, 3949, 4041, 4076, 4089, 4093, 4095, 4096. For k < 10 the value is the negation of the value at 20 − k.
- R4: For an input x with x_k ≤ x < x_(k+1), the output is y_k + floor((y_(k+1) − y_k)·(x − x_k) / 2048).
- R5: Any input below -20480 gives the node value y_0 of the selected curve.
- R6: Any input at or above 20480 gives the node value y_20 of the selected curve.
- R7: The curve select is captured with each sample. A change of `in_sel` between back-to-back samples affects only the samples taken after the change.
- R8: While `out_valid` is low, `out_y` keeps the last result it showed.
- R9: While reset is asserted, and after reset until the first result, `out_valid` is 0 and `out_y` is 0.
- R10: An input that lies exactly on a breakpoint gives that breakpoint's node value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_x | input | 16 | Weighted-sum value, signed 4.12 |
| in_sel | input | 1 | Curve select: 0 logistic, 1 hyperbolic tangent |
| out_valid | output | 1 | Result strobe |
| out_y | output | 16 | Activation value, signed 4.12 |

## Verification
The assertions take for granted that reset is asserted at start-up and that `in_valid` stays low while reset is applied, so the valid pipeline starts empty. They also take for granted that `in_x` and `in_sel` hold defined values whenever `in_valid` is high. The stimulus changes inputs only on falling edges and drops `in_valid` at random to open gaps. It draws inputs over the whole signed 16-bit range, so the clamp regions and every interior segment are reached, and it aims fixed cases at each breakpoint and at the codes on either side of both ends.

// File: rtl/pwl_act.sv
module pwl_act (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic signed [15:0] in_x,
  input  logic               in_sel,
  output logic               out_valid,
  output logic signed [15:0] out_y
);
  localparam int NODES = 21;
  localparam int MID   = NODES / 2;
  localparam int SEGS  = NODES + 1;
  localparam int SEG_W = $clog2(SEGS);
  localparam int FRAC  = 12;
  localparam int STEP  = 2048;
  localparam int X0    = -MID * STEP;
  localparam int ONE   = 1 << FRAC;

  localparam logic signed [15:0] LOGI [0:10] = '{
    16'sd2048, 16'sd2550, 16'sd2994, 16'sd3349, 16'sd3608, 16'sd3785,
    16'sd3902, 16'sd3976, 16'sd4022, 16'sd4051, 16'sd4069};
  localparam logic signed [15:0] HTAN [0:10] = '{
    16'sd0,    16'sd1893, 16'sd3119, 16'sd3707, 16'sd3949, 16'sd4041,
    16'sd4076, 16'sd4089, 16'sd4093, 16'sd4095, 16'sd4096};

  function automatic int node(input logic sel, input int k);
    if (sel) return (k >= MID) ? int'(HTAN[k-MID]) : -int'(HTAN[MID-k]);
    else     return (k >= MID) ? int'(LOGI[k-MID]) : ONE - int'(LOGI[MID-k]);
  endfunction

  function automatic int seg_slope(input logic sel, input int s);
    if (s == 0 || s == SEGS - 1) return 0;
    return (node(sel, s) - node(sel, s - 1)) * (ONE / STEP);
  endfunction

  function automatic int seg_icpt(input logic sel, input int s);
    if (s == 0)        return node(sel, 0);
    if (s == SEGS - 1) return node(sel, NODES - 1);
    return node(sel, s - 1) - (node(sel, s) - node(sel, s - 1)) * (s - 1 - MID);
  endfunction

  logic [SEG_W-1:0] seg_c;
  always_comb begin
    seg_c = '0;
    for (int k = 0; k < NODES; k++)
      if (int'(in_x) >= X0 + k * STEP) seg_c = SEG_W'(k + 1);
  end

  logic                    v1, v2, v3;
  logic [SEG_W-1:0]        seg1;
  logic                    sel1;
  logic signed [15:0]      x1, x2, slope2, icpt2, icpt3;
  logic signed [31:0]      prod3;
  logic signed [15:0]      slope_c, icpt_c, sum_c;

  assign slope_c = 16'(seg_slope(sel1, int'(seg1)));
  assign icpt_c  = 16'(seg_icpt(sel1, int'(seg1)));
  assign sum_c   = 16'(prod3 >>> FRAC) + icpt3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {v1, v2, v3, out_valid} <= '0;
      seg1 <= '0; sel1 <= 1'b0; x1 <= '0; x2 <= '0;
      slope2 <= '0; icpt2 <= '0; icpt3 <= '0; prod3 <= '0;
      out_y <= '0;
    end else begin
      v1 <= in_valid; v2 <= v1; v3 <= v2; out_valid <= v3;
      if (in_valid) begin seg1 <= seg_c; sel1 <= in_sel; x1 <= in_x; end
      if (v1) begin slope2 <= slope_c; icpt2 <= icpt_c; x2 <= x1; end
      if (v2) begin prod3 <= slope2 * x2; icpt3 <= icpt2; end
      if (v3) out_y <= sum_c;
    end
  end
endmodule

// File: rtl/pwl_act_chk.sv
module pwl_act_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic signed [15:0] in_x,
  input logic               in_sel,
  input logic               out_valid,
  input logic signed [15:0] out_y
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 3'd4) age <= age + 3'd1;

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_y));

  p_low_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd4 && $past(in_valid && !in_sel && in_x < -16'sd20480, 4)) |-> out_y == 16'sd27);

  p_high_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd4 && $past(in_valid && in_sel && in_x >= 16'sd20480, 4)) |-> out_y == 16'sd4096);

  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_y >= -16'sd4096 && out_y <= 16'sd4096));
endmodule

bind pwl_act pwl_act_chk u_chk (.*);

// File: tb/sim_pwl_act.sv
module sim_pwl_act;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_sel = 1'b0;
  logic signed [15:0] in_x = '0;
  logic out_valid;
  logic signed [15:0] out_y;

  pwl_act u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
              .in_sel(in_sel), .out_valid(out_valid), .out_y(out_y));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int exp_q[$], cyc_q[$];
  string tag_q[$];
  logic signed [15:0] last_y = '0;
  bit done = 0;

  int lpos [0:10] = '{2048, 2550, 2994, 3349, 3608, 3785, 3902, 3976, 4022, 4051, 4069};
  int tpos [0:10] = '{0, 1893, 3119, 3707, 3949, 4041, 4076, 4089, 4093, 4095, 4096};

  function automatic int yk(input bit s, input int k);
    if (s) return (k >= 10) ? tpos[k-10] : -tpos[10-k];
    return (k >= 10) ? lpos[k-10] : 4096 - lpos[10-k];
  endfunction

  function automatic int model(input bit s, input int x);
    int k, xk, dy;
    if (x < -20480) return yk(s, 0);
    if (x >= 20480) return yk(s, 20);
    k  = (x + 20480) / 2048;
    xk = -20480 + 2048 * k;
    dy = yk(s, k + 1) - yk(s, k);
    return yk(s, k) + ((dy * (x - xk)) >>> 11);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input int x, input bit s, input string req);
    @(negedge clk);
    cyc++;
    if (out_valid) begin
      if (exp_q.size() == 0) check("R1", 1, 0);
      else begin
        check(tag_q.pop_front(), int'(out_y), exp_q.pop_front());
        check("R1", cyc - cyc_q.pop_front(), 4);
      end
      last_y = out_y;
    end else begin
      check("R8", int'(out_y), int'(last_y));
    end
    in_valid = v; in_x = 16'(x); in_sel = s;
    if (v) begin exp_q.push_back(model(s, x)); cyc_q.push_back(cyc); tag_q.push_back(req); end
  endtask

  task automatic finish_up;
    if (done) return;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R9", int'(out_valid), 0);
    check("R9", int'(out_y), 0);
    rst_n = 1'b1;
    step(0, 0, 0, "R9");
    check("R9", int'(out_y), 0);
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 21; k++) step(1, -20480 + 2048 * k, s[0], "R10");
    step(1, -32768, 0, "R5"); step(1, -20481, 0, "R5");
    step(1, -32768, 1, "R5"); step(1, -20481, 1, "R5");
    step(1, 20480, 0, "R6"); step(1, 32767, 0, "R6");
    step(1, 20480, 1, "R6"); step(1, 32767, 1, "R6");
    step(1, 20479, 1, "R4"); step(1, -20479, 0, "R4");
    step(1, -1, 1, "R3"); step(1, 1, 1, "R3");
    step(1, -1, 0, "R2"); step(1, 1, 0, "R2");
    step(1, 1000, 0, "R7"); step(1, 1000, 1, "R7"); step(1, 1000, 0, "R7");
    repeat (6) step(0, 0, 0, "R8");
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 4) != 0;
      bit s = $urandom % 2;
      int x = (($urandom % 3) == 0) ? int'($signed(16'($urandom)))
                                     : int'($urandom % 45056) - 22528;
      step(v, x, s, "R4");
    end
    repeat (8) step(0, 0, 0, "R8");
    check("R1", exp_q.size(), 0);
    finish_up();
  end
endmodule